// File: doc/BRIEF.md
# Card Presence Event Detector

This block watches the status pins of two card sockets. Each socket has two card-detect pins, two battery-voltage pins, a ready pin and a write-protect pin. It also has an access-timeout strobe and a card I/O request line. Every pin passes through a flop synchroniser. Each change on a level pin, and each cycle in which the timeout or I/O line is high, sets a bit in that socket's interrupt status register. Software clears these bits by writing ones to an acknowledge mask. A status interrupt output is asserted while any latched bit is also enabled.

The block compares the two detect levels of each socket with a per-socket occupied flag. From this it derives insertion and removal events, and each event is reported once. Events are queued in a small first-in, first-out buffer that the host drains with a pop strobe. Each entry holds an event type and a socket number. Two more per-socket outputs work from the same status bits. One qualifies battery-voltage changes as alerts. The other steers the card I/O request either to a forwarded interrupt or to a spurious flag.

Top module: `cpd_detector`

## Requirements
- R1: An insertion event is queued only when both detect pins of a socket are high and the socket is not occupied. Queuing it sets the occupied flag, so further toggling of a single pin produces no event.
- R2: A removal event is queued only when both detect pins of a socket are low and the socket is occupied. Queuing it clears the occupied flag.
- R3: The queue head presents `evt_kind` (0 = insertion, 1 = removal) and `evt_sock` (the socket index, 0 or 1) while `evt_valid` is high.
- R4: Events leave the queue in the order they entered, and one entry is removed per cycle in which `evt_pop` is high and the queue is not empty.
- R5: Each socket has 7 status bits, found at `stat_flags[7*s + k]`. A cycle with `ack_wr` high clears every bit whose `ack_mask` bit is one, so a mask of 0x3FFF clears all 14 bits. A new setting condition in the same cycle takes priority over the clear.
- R6: Status bit k records the following: k=0 a change on either detect pin; k=1 a change on battery pin 1; k=2 a change on battery pin 2; k=3 a change on ready; k=4 a change on write-protect; k=5 access timeout high; k=6 card I/O request high.
- R7: `bat_alert[s]` is high when battery bit 1 or 2 of socket s is latched and its detect-change bit is not latched.
- R8: While the I/O request bit of socket s is latched, `card_irq[s]` is high if the socket is occupied; otherwise `spurious[s]` is high instead.
- R9: When both sockets are due an event in the same cycle, the socket 0 event is queued first and the socket 1 event in the next cycle.
- R10: `stat_irq` is high exactly when some bit of `stat_flags & irq_en` is set.
- R11: The queue holds 8 entries. An event that arrives while it is full and not being popped is discarded, and `evt_ovf` is set and stays set until reset. The occupied flag still updates.
- R12: An input change reaches the status register on the third rising clock edge after it occurs, and not earlier. The two synchroniser flops account for this delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cd_a | input | NUM_SOCK | First card-detect pin per socket, high = contact |
| cd_b | input | NUM_SOCK | Second card-detect pin per socket, high = contact |
| bv1 | input | NUM_SOCK | Battery-voltage pin 1 per socket |
| bv2 | input | NUM_SOCK | Battery-voltage pin 2 per socket |
| rdy | input | NUM_SOCK | Ready/busy pin per socket |
| wp | input | NUM_SOCK | Write-protect pin per socket |
| acc_to | input | NUM_SOCK | Access-timeout strobe per socket |
| card_io | input | NUM_SOCK | Card I/O request per socket |
| ack_wr | input | 1 | Acknowledge strobe |
| ack_mask | input | 7*NUM_SOCK | Write-one-to-clear mask for status bits |
| irq_en | input | 7*NUM_SOCK | Per-bit enable for the status interrupt |
| evt_pop | input | 1 | Removes the queue head |
| evt_valid | output | 1 | Queue not empty |
| evt_kind | output | 1 | Head event type, 0 insertion, 1 removal |
| evt_sock | output | SOCK_W | Head event socket index |
| evt_ovf | output | 1 | Sticky queue overflow flag |
| occupied | output | NUM_SOCK | Per-socket occupied flag |
| stat_flags | output | 7*NUM_SOCK | Latched status bits of all sockets |
| stat_irq | output | 1 | Status-change interrupt |
| bat_alert | output | NUM_SOCK | Qualified battery change per socket |
| card_irq | output | NUM_SOCK | Forwarded card I/O interrupt |
| spurious | output | NUM_SOCK | I/O request on an unoccupied socket |

## Verification
The assertions assume that the pins are asynchronous levels. They also assume that a pop on an empty queue is harmless and that the host sends acknowledges without regard to when status bits are being set. Under those assumptions they check how the occupied flag follows the queued events, how the queue count behaves at its bounds, and that set takes priority over clear. The stimulus changes pins only at falling edges and holds each level for at least four cycles, so that every edge is seen exactly once. It keeps the timeout strobe high for one full cycle so the synchroniser captures it. It keeps acknowledge and pop to single-cycle strobes.

// File: rtl/cpd_pkg.sv
// Shared constants for the card presence event detector.
// Assumes a fixed 7-bit status layout per socket. The bit positions are
// visible to software through the flattened status output.
package cpd_pkg;
    localparam int ST_W   = 7;
    localparam int ST_DET = 0;
    localparam int ST_BV1 = 1;
    localparam int ST_BV2 = 2;
    localparam int ST_RDY = 3;
    localparam int ST_WP  = 4;
    localparam int ST_TMO = 5;
    localparam int ST_CIO = 6;

    typedef enum logic {
        EV_INSERT = 1'b0,
        EV_REMOVE = 1'b1
    } ev_kind_e;
endpackage

// File: rtl/cpd_sync.sv
// Multi-stage flop synchroniser for a vector of asynchronous levels.
// Assumes each bit is independent, so no bus coherency is needed, and that
// STAGES >= 1.
module cpd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw input into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_rest
            // Pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cpd_socket_mon.sv
// Per-socket monitor. It synchronises the socket pins, detects level
// changes, keeps the write-one-to-clear status register and the occupied
// flag, and raises insertion or removal requests. It assumes the top grants
// at most one request per cycle and only a request that is raised.
module cpd_socket_mon
    import cpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cd_a,
    input  logic            cd_b,
    input  logic            bv1,
    input  logic            bv2,
    input  logic            rdy,
    input  logic            wp,
    input  logic            acc_to,
    input  logic            card_io,
    input  logic            ack_wr,
    input  logic [ST_W-1:0] ack_bits,
    input  logic            grant,
    output logic            ins_req,
    output logic            rem_req,
    output logic            occ,
    output logic [ST_W-1:0] st_q,
    output logic            bat_alert,
    output logic            card_irq,
    output logic            spurious
);
    localparam int LVL_W = 6;
    localparam int IN_W  = LVL_W + 2;

    logic [IN_W-1:0]  raw_in;
    logic [IN_W-1:0]  syn;
    logic [LVL_W-1:0] prev_lvl;
    logic [LVL_W-1:0] lvl_edge;
    logic [ST_W-1:0]  st_set;
    logic [ST_W-1:0]  st_clr;

    assign raw_in = {card_io, acc_to, wp, rdy, bv2, bv1, cd_b, cd_a};

    cpd_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn)
    );

    // Hold last cycle's synchronised levels for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= '0;
        else        prev_lvl <= syn[LVL_W-1:0];
    end

    assign lvl_edge = syn[LVL_W-1:0] ^ prev_lvl;

    // Map each detected condition onto its status bit.
    always_comb begin
        st_set         = '0;
        st_set[ST_DET] = lvl_edge[0] | lvl_edge[1];
        st_set[ST_BV1] = lvl_edge[2];
        st_set[ST_BV2] = lvl_edge[3];
        st_set[ST_RDY] = lvl_edge[4];
        st_set[ST_WP]  = lvl_edge[5];
        st_set[ST_TMO] = syn[6];
        st_set[ST_CIO] = syn[7];
    end

    assign st_clr = ack_wr ? ack_bits : '0;

    // Status register: clear on acknowledge, new conditions win.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~st_clr) | st_set;
    end

    assign ins_req = syn[0] & syn[1] & ~occ;
    assign rem_req = ~syn[0] & ~syn[1] & occ;

    // Occupied flag follows granted insertion or removal requests.
    always_ff @(posedge clk) begin
        if (!rst_n)                  occ <= 1'b0;
        else if (grant && ins_req)   occ <= 1'b1;
        else if (grant && rem_req)   occ <= 1'b0;
    end

    assign bat_alert = (st_q[ST_BV1] | st_q[ST_BV2]) & ~st_q[ST_DET];
    assign card_irq  = st_q[ST_CIO] & occ;
    assign spurious  = st_q[ST_CIO] & ~occ;

    // R5: a set condition is visible on the next cycle despite any ack.
    p_status_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_set != '0) |=> ((st_q & $past(st_set)) == $past(st_set)));

    // R1/R2: the occupied flag changes only in a granted cycle.
    p_occ_needs_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(occ) |-> $past(grant));
endmodule

// File: rtl/cpd_event_fifo.sv
// Event queue with a single push and a single pop port. It assumes push
// data is a flat {kind, socket} word. When full, a push without a
// simultaneous pop is discarded and a sticky overflow flag is set.
module cpd_event_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] head,
    output logic          ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          do_pop;
    logic          do_push;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != FULL_CNT) || do_pop);

    // Storage write at the tail.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky overflow on a discarded event.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ovf <= 1'b0;
        else if (push && !do_push)  ovf <= 1'b1;
    end

    assign valid = (count != '0);
    assign head  = mem[rd_ptr];

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    p_drop_when_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push && !pop) |=> (count == FULL_CNT && ovf));

    p_pop_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && valid && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/cpd_detector.sv
// Top of the card presence event detector. It instantiates one monitor per
// socket, grants event requests lowest socket first (one per cycle), and
// queues the events. It assumes the host pops only while evt_valid is high,
// though a pop on an empty queue is ignored.
module cpd_detector
    import cpd_pkg::*;
#(
    parameter int  NUM_SOCK    = 2,
    parameter int  FIFO_DEPTH  = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int ST_TOT      = NUM_SOCK * ST_W,
    localparam int SOCK_W      = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SOCK-1:0] cd_a,
    input  logic [NUM_SOCK-1:0] cd_b,
    input  logic [NUM_SOCK-1:0] bv1,
    input  logic [NUM_SOCK-1:0] bv2,
    input  logic [NUM_SOCK-1:0] rdy,
    input  logic [NUM_SOCK-1:0] wp,
    input  logic [NUM_SOCK-1:0] acc_to,
    input  logic [NUM_SOCK-1:0] card_io,
    input  logic                ack_wr,
    input  logic [ST_TOT-1:0]   ack_mask,
    input  logic [ST_TOT-1:0]   irq_en,
    input  logic                evt_pop,
    output logic                evt_valid,
    output logic                evt_kind,
    output logic [SOCK_W-1:0]   evt_sock,
    output logic                evt_ovf,
    output logic [NUM_SOCK-1:0] occupied,
    output logic [ST_TOT-1:0]   stat_flags,
    output logic                stat_irq,
    output logic [NUM_SOCK-1:0] bat_alert,
    output logic [NUM_SOCK-1:0] card_irq,
    output logic [NUM_SOCK-1:0] spurious
);
    localparam int EV_W = SOCK_W + 1;

    logic [NUM_SOCK-1:0] ins_req;
    logic [NUM_SOCK-1:0] rem_req;
    logic [NUM_SOCK-1:0] grant;
    logic                push;
    logic                push_kind;
    logic [SOCK_W-1:0]   push_sock;
    logic [EV_W-1:0]     head;

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        cpd_socket_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .cd_a      (cd_a[s]),
            .cd_b      (cd_b[s]),
            .bv1       (bv1[s]),
            .bv2       (bv2[s]),
            .rdy       (rdy[s]),
            .wp        (wp[s]),
            .acc_to    (acc_to[s]),
            .card_io   (card_io[s]),
            .ack_wr    (ack_wr),
            .ack_bits  (ack_mask[s*ST_W +: ST_W]),
            .grant     (grant[s]),
            .ins_req   (ins_req[s]),
            .rem_req   (rem_req[s]),
            .occ       (occupied[s]),
            .st_q      (stat_flags[s*ST_W +: ST_W]),
            .bat_alert (bat_alert[s]),
            .card_irq  (card_irq[s]),
            .spurious  (spurious[s])
        );
    end

    // Fixed-priority scan: the lowest-numbered requesting socket wins.
    always_comb begin
        grant     = '0;
        push      = 1'b0;
        push_kind = EV_INSERT;
        push_sock = '0;
        for (int s = 0; s < NUM_SOCK; s++) begin
            if (!push && (ins_req[s] || rem_req[s])) begin
                push      = 1'b1;
                grant[s]  = 1'b1;
                push_kind = rem_req[s] ? EV_REMOVE : EV_INSERT;
                push_sock = SOCK_W'(s);
            end
        end
    end

    cpd_event_fifo #(.DEPTH(FIFO_DEPTH), .DW(EV_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data ({push_kind, push_sock}),
        .pop       (evt_pop),
        .valid     (evt_valid),
        .head      (head),
        .ovf       (evt_ovf)
    );

    assign evt_kind = head[EV_W-1];
    assign evt_sock = head[SOCK_W-1:0];
    assign stat_irq = |(stat_flags & irq_en);

    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_ins_sets_occ_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_kind == EV_INSERT) |=> occupied[$past(push_sock)]);

    p_rem_clears_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_kind == EV_REMOVE) |=> !occupied[$past(push_sock)]);
endmodule

// File: tb/cpd_detector_tb.sv
// Directed bench for cpd_detector. There is one task per scenario, inputs
// are driven at falling edges and outputs are sampled at falling edges.
module cpd_detector_tb;
    localparam int NS  = 2;
    localparam int STT = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   cd_a = '0, cd_b = '0, bv1 = '0, bv2 = '0;
    logic [NS-1:0]   rdy = '0, wp = '0, acc_to = '0, card_io = '0;
    logic            ack_wr = 1'b0;
    logic [STT-1:0]  ack_mask = '0;
    logic [STT-1:0]  irq_en = '0;
    logic            evt_pop = 1'b0;
    logic            evt_valid, evt_kind, evt_ovf, stat_irq;
    logic [0:0]      evt_sock;
    logic [NS-1:0]   occupied, bat_alert, card_irq, spurious;
    logic [STT-1:0]  stat_flags;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpd_detector u_dut (
        .clk(clk), .rst_n(rst_n), .cd_a(cd_a), .cd_b(cd_b), .bv1(bv1),
        .bv2(bv2), .rdy(rdy), .wp(wp), .acc_to(acc_to), .card_io(card_io),
        .ack_wr(ack_wr), .ack_mask(ack_mask), .irq_en(irq_en),
        .evt_pop(evt_pop), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_sock(evt_sock), .evt_ovf(evt_ovf), .occupied(occupied),
        .stat_flags(stat_flags), .stat_irq(stat_irq), .bat_alert(bat_alert),
        .card_irq(card_irq), .spurious(spurious)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_one();
        evt_pop = 1'b1;
        tick(1);
        evt_pop = 1'b0;
    endtask

    task automatic ack(input logic [STT-1:0] m);
        ack_wr = 1'b1;
        ack_mask = m;
        tick(1);
        ack_wr = 1'b0;
        ack_mask = '0;
    endtask

    task automatic expect_head(input string req, input int kind, input int sock);
        check({req, " valid"}, int'(evt_valid), 1);
        check({req, " kind"}, int'(evt_kind), kind);
        check({req, " sock"}, int'(evt_sock), sock);
    endtask

    task automatic t_reset();
        check("R3 reset valid", int'(evt_valid), 0);
        check("R1 reset occupied", int'(occupied), 0);
        check("R5 reset flags", int'(stat_flags), 0);
        check("R10 reset irq", int'(stat_irq), 0);
        check("R11 reset ovf", int'(evt_ovf), 0);
    endtask

    task automatic t_sync_latency();
        cd_a[0] = 1'b1;
        tick(2);
        check("R12 not before third edge", int'(stat_flags[0]), 0);
        tick(1);
        check("R12 set on third edge", int'(stat_flags[0]), 1);
        tick(2);
        check("R1 single pin no event", int'(evt_valid), 0);
    endtask

    task automatic t_insert();
        cd_b[0] = 1'b1;
        tick(4);
        expect_head("R1 R3 insert s0", 0, 0);
        check("R1 occupied set", int'(occupied[0]), 1);
        pop_one();
        check("R4 empty after pop", int'(evt_valid), 0);
        cd_b[0] = 1'b0; tick(4);
        cd_b[0] = 1'b1; tick(4);
        check("R1 duplicate suppressed", int'(evt_valid), 0);
        check("R1 still occupied", int'(occupied[0]), 1);
    endtask

    task automatic t_remove();
        cd_a[0] = 1'b0;
        cd_b[0] = 1'b0;
        tick(4);
        expect_head("R2 R3 remove s0", 1, 0);
        check("R2 occupied cleared", int'(occupied[0]), 0);
        pop_one();
    endtask

    task automatic t_ack();
        ack(14'h3FFF);
        check("R5 full clear", int'(stat_flags), 0);
        rdy[0] = 1'b1;
        wp[0] = 1'b1;
        tick(4);
        ack(14'h0008);
        check("R5 partial clear", int'(stat_flags), 32'h10);
        ack(14'h3FFF);
    endtask

    task automatic t_status_bits();
        bv1[1] = 1'b1;
        rdy[1] = 1'b1;
        wp[1] = 1'b1;
        acc_to[1] = 1'b1;
        tick(1);
        acc_to[1] = 1'b0;
        tick(4);
        check("R6 socket1 bits", int'(stat_flags), (1 << 8) | (1 << 10) | (1 << 11) | (1 << 12));
        check("R7 alert s1", int'(bat_alert[1]), 1);
        ack(14'h3FFF);
        tick(2);
        check("R6 timeout not relatched", int'(stat_flags), 0);
    endtask

    task automatic t_battery();
        bv1[0] = 1'b1;
        tick(4);
        check("R7 alert alone", int'(bat_alert[0]), 1);
        ack(14'h3FFF);
        bv2[0] = 1'b1;
        cd_a[0] = 1'b1;
        tick(4);
        check("R6 det and bv2", int'(stat_flags), 32'h5);
        check("R7 suppressed by detect", int'(bat_alert[0]), 0);
        ack(14'h0001);
        check("R7 alert after detect ack", int'(bat_alert[0]), 1);
        cd_a[0] = 1'b0;
        tick(4);
        ack(14'h3FFF);
    endtask

    task automatic t_irq();
        irq_en = '1;
        tick(1);
        check("R10 no flags no irq", int'(stat_irq), 0);
        rdy[0] = 1'b0;
        tick(4);
        irq_en = ~14'h0008;
        tick(1);
        check("R10 masked", int'(stat_irq), 0);
        irq_en = 14'h0008;
        tick(1);
        check("R10 enabled", int'(stat_irq), 1);
        ack(14'h3FFF);
        check("R10 cleared", int'(stat_irq), 0);
    endtask

    task automatic t_io();
        card_io[1] = 1'b1;
        tick(4);
        check("R8 spurious", int'(spurious[1]), 1);
        check("R8 not forwarded", int'(card_irq[1]), 0);
        card_io[1] = 1'b0;
        tick(4);
        ack(14'h3FFF);
        check("R8 spurious cleared", int'(spurious[1]), 0);
        cd_a[1] = 1'b1;
        cd_b[1] = 1'b1;
        tick(4);
        expect_head("R3 insert s1", 0, 1);
        pop_one();
        card_io[1] = 1'b1;
        tick(4);
        check("R8 forwarded", int'(card_irq[1]), 1);
        check("R8 not spurious", int'(spurious[1]), 0);
        card_io[1] = 1'b0;
        tick(4);
        ack(14'h3FFF);
    endtask

    task automatic t_order();
        cd_a[1] = 1'b0;
        cd_b[1] = 1'b0;
        tick(4);
        expect_head("R2 remove s1", 1, 1);
        pop_one();
        ack(14'h3FFF);
        cd_a = 2'b11;
        cd_b = 2'b11;
        tick(5);
        expect_head("R9 first socket0", 0, 0);
        pop_one();
        expect_head("R9 then socket1", 0, 1);
        pop_one();
        check("R4 drained", int'(evt_valid), 0);
        ack(14'h3FFF);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) begin
            cd_a[0] = (i % 2 == 1);
            cd_b[0] = (i % 2 == 1);
            tick(4);
            if (i == 7) check("R11 no ovf at eight", int'(evt_ovf), 0);
        end
        check("R11 ovf set", int'(evt_ovf), 1);
        check("R11 occupied still updated", int'(occupied[0]), 0);
        for (int j = 0; j < 8; j++) begin
            expect_head("R4 R11 fifo order", (j % 2 == 0) ? 1 : 0, 0);
            pop_one();
        end
        check("R11 ninth dropped", int'(evt_valid), 0);
        check("R11 ovf sticky", int'(evt_ovf), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_sync_latency();
        t_insert();
        t_remove();
        t_ack();
        t_status_bits();
        t_battery();
        t_irq();
        t_io();
        t_order();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule